// File: doc/BRIEF.md
# SPI Master Shift Engine

This engine sits between a transmit FIFO and a receive FIFO inside a synchronous serial port. It takes the oldest waiting transmit word, shifts it out on a master-side SPI link with the most significant bit first, and collects one incoming bit per serial clock. When the frame ends, it pushes the collected word into the receive FIFO. Every word sent gives exactly one word received, and the order of the words is kept.

The engine runs only while the port is enabled and the slave-select control is clear. It starts a word only when it can be sure the result has somewhere to go, so the receive FIFO can never overrun. When a word does not fit, the engine stalls. In loopback mode the data-in pin is ignored, and the received word is the transmitted word itself. The frame length comes from a 4-bit width field and runs from 1 to 16 bits. The serial clock rate comes from a prescale value.

Both FIFO sides use valid/ready. On the transmit side, `tx_valid` means a word is waiting. The engine pops that word by raising `tx_ready` for one cycle, and only in a cycle where `tx_valid` and `rx_ready` are both high. On the receive side, `rx_ready` means one free slot. The engine raises `rx_valid` for exactly one cycle per word. Because the slot was reserved when the word was popped, the receiver must not withdraw `rx_ready` between the pop and the push. The configuration inputs are plain levels.

Top module: `spi_shift_engine`

## Requirements
- R1: No word is popped and chip select stays high while `cfg_enable` is low.
- R2: A word is popped only in a cycle where `tx_valid` and `rx_ready` are both high. When the receiver has no free slot, the engine waits, and `rx_valid` is never raised without `rx_ready`.
- R3: Words are sent in the order they were popped, and each received word is pushed in that same order.
- R4: With `cfg_loopback` high, the received word equals the transmitted word (masked to the frame width), whatever `miso` does.
- R5: A frame carries `cfg_width_m1`+1 bits, and the pushed word has every bit above that width cleared.
- R6: With `cfg_slave_sel` high, the engine stays idle: nothing is popped and chip select stays high.
- R7: `sclk` idles low and stays high for max(`cfg_prescale`,2) system clocks in each bit. `mosi` changes only while `sclk` is low, `miso` is sampled as `sclk` rises, and bits go out most significant first.
- R8: `cs_n` is low for the whole frame, including every `sclk` pulse. Between two frames it stays high for at least one full serial clock period (2×max(prescale,2) clocks).
- R9: `busy` is high from the cycle after a pop until the received word is pushed, and low when the engine is idle.
- R10: Clearing `cfg_enable` during a frame lets that frame finish and push its word. After that, no further word starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port enable |
| cfg_loopback | input | 1 | Internal loopback: received data is the sent data |
| cfg_slave_sel | input | 1 | Slave-mode request (unsupported; holds engine idle) |
| cfg_width_m1 | input | $clog2(DW) | Frame length minus one |
| cfg_prescale | input | PW | Half serial-clock period in system clocks (minimum 2 used) |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_ready | output | 1 | Pop strobe for the transmit FIFO |
| tx_data | input | DW | Oldest transmit word |
| rx_valid | output | 1 | Push strobe for the receive FIFO |
| rx_ready | input | 1 | Receive FIFO has a free slot |
| rx_data | output | DW | Received word, masked to frame width |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word in flight |

## Verification
A wrong bit counter shows up as an extra or missing `sclk` rise within the same frame, and as a received word that is shifted or carries stray upper bits. A stuck or mis-timed divider shows up in the very next high phase of `sclk` as the wrong length. A broken start condition shows up as a chip-select fall while disabled or while the receiver is full. A broken transmit shift shows up as a wrong `mosi` bit sequence at the first frame. A word lost or duplicated in the handshake shows up as a shift in the received sequence when three words are queued back to back.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_PUSH,
    ST_GAP1,
    ST_GAP2
  } eng_state_t;
endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [PW-1:0] half_len,
  output logic          tick
);
  logic [PW-1:0] cnt;

  assign tick = !clear && (cnt == half_len - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else                   cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter  int DW = 16,
  localparam int WW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift_en,
  input  logic          sample_en,
  input  logic          frame_active,
  input  logic          loopback,
  input  logic [WW-1:0] width_m1,
  input  logic [DW-1:0] tx_data,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_data
);
  logic [DW-1:0] tx_sr, rx_sr, mask;
  logic [WW-1:0] width_q;
  logic          out_bit, in_bit;

  assign out_bit = tx_sr[width_q];
  assign in_bit  = loopback ? out_bit : miso;
  assign mosi    = frame_active & out_bit;

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i <= int'(width_q));
  end
  assign rx_data = rx_sr & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      width_q <= '0;
    end else if (load) begin
      tx_sr   <= tx_data;
      rx_sr   <= '0;
      width_q <= width_m1;
    end else begin
      if (shift_en)  tx_sr <= tx_sr << 1;
      if (sample_en) rx_sr <= {rx_sr[DW-2:0], in_bit};
    end
  end
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter  int DW = 16,
  parameter  int PW = 8,
  localparam int WW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_slave_sel,
  input  logic [WW-1:0] cfg_width_m1,
  input  logic [PW-1:0] cfg_prescale,
  input  logic          tx_valid,
  input  logic          rx_ready,
  input  logic          tick,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic          load,
  output logic          sample_en,
  output logic          shift_en,
  output logic          div_clear,
  output logic          sclk,
  output logic          cs_n,
  output logic          busy,
  output logic [PW-1:0] half_len
);
  eng_state_t    st, st_nx;
  logic [WW-1:0] bits_left;
  logic          done_q;
  logic          go;

  assign go        = (st == ST_IDLE) && cfg_enable && !cfg_slave_sel && tx_valid && rx_ready;
  assign tx_ready  = go;
  assign load      = go;
  assign rx_valid  = (st == ST_PUSH);
  assign sclk      = (st == ST_HIGH);
  assign cs_n      = !((st == ST_LOW) || (st == ST_HIGH));
  assign busy      = (st == ST_LOW) || (st == ST_HIGH) || (st == ST_PUSH);
  assign div_clear = (st == ST_IDLE) || (st == ST_PUSH);
  assign sample_en = (st == ST_LOW) && tick;
  assign shift_en  = (st == ST_HIGH) && tick && !done_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (go)   st_nx = ST_LOW;
      ST_LOW:  if (tick) st_nx = ST_HIGH;
      ST_HIGH: if (tick) st_nx = done_q ? ST_PUSH : ST_LOW;
      ST_PUSH:           st_nx = ST_GAP1;
      ST_GAP1: if (tick) st_nx = ST_GAP2;
      ST_GAP2: if (tick) st_nx = ST_IDLE;
      default:           st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bits_left <= '0;
      done_q    <= 1'b0;
      half_len  <= PW'(2);
    end else begin
      st <= st_nx;
      if (go) begin
        bits_left <= cfg_width_m1;
        done_q    <= 1'b0;
        half_len  <= (cfg_prescale < PW'(2)) ? PW'(2) : cfg_prescale;
      end else if (sample_en) begin
        if (bits_left == '0) done_q <= 1'b1;
        else                 bits_left <= bits_left - WW'(1);
      end
    end
  end

  AST_START_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(cfg_enable && !cfg_slave_sel)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_ready); // R2
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R8
  AST_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> busy); // R9
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter  int DW = 16,
  parameter  int PW = 8,
  localparam int WW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_loopback,
  input  logic          cfg_slave_sel,
  input  logic [WW-1:0] cfg_width_m1,
  input  logic [PW-1:0] cfg_prescale,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso,
  output logic          busy
);
  logic          load, sample_en, shift_en, div_clear, tick;
  logic [PW-1:0] half_len;

  spi_eng_ctrl #(.DW(DW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_slave_sel(cfg_slave_sel),
    .cfg_width_m1(cfg_width_m1), .cfg_prescale(cfg_prescale),
    .tx_valid(tx_valid), .rx_ready(rx_ready), .tick(tick),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .load(load),
    .sample_en(sample_en), .shift_en(shift_en), .div_clear(div_clear),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .half_len(half_len)
  );

  spi_eng_clkdiv #(.PW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(div_clear),
    .half_len(half_len), .tick(tick)
  );

  spi_eng_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .sample_en(sample_en), .frame_active(!cs_n), .loopback(cfg_loopback),
    .width_m1(cfg_width_m1), .tx_data(tx_data), .miso(miso),
    .mosi(mosi), .rx_data(rx_data)
  );

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R7
endmodule

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_enable = 1'b0, cfg_loopback = 1'b0, cfg_slave_sel = 1'b0;
  logic [3:0]  cfg_width_m1 = 4'd15;
  logic [7:0]  cfg_prescale = 8'd2;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, sclk, cs_n, mosi, miso, busy;
  logic [15:0] tx_data, rx_data;

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback),
    .cfg_slave_sel(cfg_slave_sel), .cfg_width_m1(cfg_width_m1),
    .cfg_prescale(cfg_prescale), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // FIFO models
  logic [15:0] tx_mem [8];
  logic [15:0] rx_mem [8];
  logic [7:0]  tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0;
  int          rx_cap = 4;
  assign tx_valid = (tx_wr != tx_rd);
  assign tx_data  = tx_mem[tx_rd[2:0]];
  assign rx_ready = int'(8'(rx_wr - rx_rd)) < rx_cap;

  // slave and line monitors
  logic [15:0] slave_word = 16'h0, slave_sh = 16'h0, mosi_cap = 16'h0;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          hi_run = 0, hi_len = 0, rise_cnt = 0, gap_run = 0, last_gap = 0, cs_falls = 0;
  assign miso = slave_sh[cfg_width_m1];

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_rd <= tx_rd + 8'd1;
    if (rx_valid && rx_ready) begin
      rx_mem[rx_wr[2:0]] <= rx_data;
      rx_wr <= rx_wr + 8'd1;
    end
    prev_sclk <= sclk;
    prev_cs   <= cs_n;
    hi_run    <= sclk ? hi_run + 1 : 0;
    if (prev_sclk && !sclk) hi_len <= hi_run;
    gap_run   <= cs_n ? gap_run + 1 : 0;
    if (prev_cs && !cs_n) begin
      last_gap <= gap_run;
      cs_falls <= cs_falls + 1;
      rise_cnt <= 0;
      mosi_cap <= 16'h0;
      slave_sh <= slave_word;
    end else begin
      if (!prev_sclk && sclk) begin
        rise_cnt <= rise_cnt + 1;
        mosi_cap <= {mosi_cap[14:0], mosi};
      end
      if (prev_sclk && !sclk && !cs_n) slave_sh <= slave_sh << 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [15:0] w);
    @(negedge clk);
    tx_mem[tx_wr[2:0]] = w;
    tx_wr = tx_wr + 8'd1;
  endtask

  task automatic wait_rx(input int n, input string req);
    int t = 0;
    while (int'(8'(rx_wr - rx_rd)) < n && t < 6000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 6000) chk(1'b0, {req, " timeout"}, t, 0);
  endtask

  task automatic pop_rx(output logic [15:0] w);
    w = rx_mem[rx_rd[2:0]];
    rx_rd = rx_rd + 8'd1;
  endtask

  function automatic logic [15:0] wmask(input int wm1);
    logic [15:0] m = 16'h0;
    for (int i = 0; i <= wm1; i++) m[i] = 1'b1;
    return m;
  endfunction

  // {loopback, width_m1, prescale, tx word, slave word}
  localparam int NV = 7;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 4'd7,  8'd2, 16'h00A5, 16'h003C},
    {1'b0, 4'd15, 8'd3, 16'hBEEF, 16'h1234},
    {1'b1, 4'd15, 8'd0, 16'hC0DE, 16'hFFFF},
    {1'b0, 4'd3,  8'd1, 16'hFFF9, 16'hABCD},
    {1'b1, 4'd0,  8'd5, 16'h0003, 16'h0000},
    {1'b0, 4'd11, 8'd4, 16'h0F0F, 16'hF5A5},
    {1'b1, 4'd9,  8'd2, 16'h03FF, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, a, b, c;
    int base, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(sclk == 1'b0, "R7 reset sclk", sclk, 0);
    chk(cs_n == 1'b1, "R8 reset cs_n", cs_n, 1);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R2 reset strobes", {tx_ready, rx_valid}, 0);

    // vector table: R4 R5 R7
    cfg_enable = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      logic [15:0] exp_rx, exp_tx;
      int wm1, pre;
      e = VEC[v];
      wm1 = int'(e[43:40]);
      pre = int'(e[39:32]);
      @(negedge clk);
      cfg_loopback = e[44];
      cfg_width_m1 = e[43:40];
      cfg_prescale = e[39:32];
      slave_word = e[15:0];
      push_tx(e[31:16]);
      wait_rx(1, "R5");
      pop_rx(got);
      exp_tx = e[31:16] & wmask(wm1);
      exp_rx = e[44] ? exp_tx : (e[15:0] & wmask(wm1));
      chk(got == exp_rx, e[44] ? "R4 loopback word" : "R5 masked word", got, exp_rx);
      chk(rise_cnt == wm1 + 1, "R5 bits per frame", rise_cnt, wm1 + 1);
      chk(hi_len == ((pre < 2) ? 2 : pre), "R7 sclk high length", hi_len, (pre < 2) ? 2 : pre);
      chk(mosi_cap == exp_tx, "R7 msb-first mosi", mosi_cap, exp_tx);
      repeat (30) @(negedge clk);
    end
    cfg_loopback = 1'b0;
    cfg_width_m1 = 4'd15;
    cfg_prescale = 8'd2;
    slave_word = 16'h5AC3;

    // R1: disabled, nothing starts
    cfg_enable = 1'b0;
    base = cs_falls;
    push_tx(16'h1111);
    repeat (80) @(negedge clk);
    chk(cs_falls == base, "R1 no frame while disabled", cs_falls - base, 0);
    chk(tx_valid == 1'b1, "R1 word left in tx fifo", tx_valid, 1);
    cfg_enable = 1'b1;
    wait_rx(1, "R1");
    pop_rx(got);
    chk(got == 16'h5AC3, "R1 word after enable", got, 16'h5AC3);
    repeat (30) @(negedge clk);

    // R6: slave request holds engine idle
    cfg_slave_sel = 1'b1;
    base = cs_falls;
    push_tx(16'h2222);
    repeat (80) @(negedge clk);
    chk(cs_falls == base && tx_valid, "R6 idle in slave mode", cs_falls - base, 0);
    cfg_slave_sel = 1'b0;
    wait_rx(1, "R6");
    pop_rx(got);
    chk(got == 16'h5AC3, "R6 word after slave cleared", got, 16'h5AC3);
    repeat (30) @(negedge clk);

    // R2, R3, R8: stall on full receiver, then ordered back-to-back words
    cfg_loopback = 1'b1;
    rx_cap = 1;
    base = cs_falls;
    a = 16'hA001; b = 16'hB002; c = 16'hC003;
    push_tx(a); push_tx(b); push_tx(c);
    wait_rx(1, "R2");
    repeat (200) @(negedge clk);
    chk(cs_falls - base == 1, "R2 stall while rx full", cs_falls - base, 1);
    chk(int'(8'(rx_wr - rx_rd)) == 1, "R2 no overrun", int'(8'(rx_wr - rx_rd)), 1);
    rx_cap = 4;
    wait_rx(3, "R3");
    h = 2;
    chk(last_gap >= 2 * h, "R8 gap between frames", last_gap, 2 * h);
    pop_rx(got); chk(got == a, "R3 order first", got, a);
    pop_rx(got); chk(got == b, "R3 order second", got, b);
    pop_rx(got); chk(got == c, "R3 order third", got, c);
    repeat (30) @(negedge clk);

    // R9 and R10: busy span, disable mid-frame
    cfg_prescale = 8'd3;
    base = cs_falls;
    push_tx(16'h7E81); push_tx(16'h1357);
    while (cs_n) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during frame", busy, 1);
    cfg_enable = 1'b0;
    wait_rx(1, "R10");
    pop_rx(got);
    chk(got == 16'h7E81, "R10 frame completes after disable", got, 16'h7E81);
    repeat (200) @(negedge clk);
    chk(cs_falls - base == 1, "R10 no new frame after disable", cs_falls - base, 1);
    chk(busy == 1'b0, "R9 idle busy low", busy, 0);
    cfg_enable = 1'b1;
    wait_rx(1, "R10");
    pop_rx(got);
    chk(got == 16'h1357, "R10 second word after re-enable", got, 16'h1357);

    repeat (20) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule